// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block drives the conversion sequencer that sits in front of an analog-to-digital converter. Software programs a 16-bit control word that sets the sampling window, the converter clock rate, the run mode and the reaction to a debug-suspend request. After a start trigger the sequencer walks through conversion slots 0 up to the value on `max_slot`. For each slot it raises `soc` for the sampling window. It then waits a fixed converter latency and pulses `latch` together with the slot number whose result is ready.

In start-stop mode the sequencer parks after the last slot and waits until `seq_clr` returns it to slot 0. In continuous mode it wraps to slot 0 without help. The run-mode bit may be rewritten at any time, but it is only consulted at the end of a sequence. A debug-suspend input can be ignored, can stop the sequencer at the end of the sequence, can stop it at the end of the current conversion, or can freeze it at once. Whichever is chosen, releasing suspend resumes exactly where it stopped.

Control word layout: bit 15 is reserved; bit 14 is the self-clearing module reset; bits 13:12 are the suspend mode; bits 11:8 are the acquisition count; bit 7 halves the converter clock; bit 6 selects continuous mode; bits 5 and 4 are spare read/write controls; bits 3:0 are reserved.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, `rd_data` is 0, `soc`, `latch`, `eos` and `busy` are 0, and `slot` is 0.
- R2: A write with bit 14 set returns the control word and the sequencer to the R1 state at the next edge, and bit 14 always reads 0.
- R3: For the two clock cycles after an accepted bit-14 write, further writes have no effect on `rd_data`; the third write after it is accepted.
- R4: Bits 15 and 3:0 read 0 whatever is written; bits 13:4 read back the written value in place.
- R5: Each `soc` pulse lasts (bits 11:8 + 1) clock cycles when bit 7 is 0, and twice that when bit 7 is 1.
- R6: A sequence converts slots 0 to `max_slot` in order, with one single-cycle `latch` per slot carrying that slot on `latch_slot`; `eos` is high for one cycle, exactly one cycle after the last slot's `latch`.
- R7: A start trigger is accepted only while the sequencer is idle; triggers while `busy` is high add no conversion.
- R8: In start-stop mode (bit 6 = 0) the sequencer stays stopped after `eos` and ignores `start` until `seq_clr` sets `slot` back to 0.
- R9: In continuous mode (bit 6 = 1) the sequencer restarts at slot 0 after `eos`; bit 6 is sampled only at the end of a sequence, so a change written mid-sequence decides whether that same sequence wraps.
- R10: With bits 13:12 = 00, `suspend` has no effect on timing or results.
- R11: With bits 13:12 = 11, `suspend` freezes `soc`, `slot` and the latency counters from the next edge. On release the sequencer resumes, so a frozen `soc` is stretched by the frozen cycles.
- R12: With bits 13:12 = 10, `suspend` lets the conversion in flight finish and latch, then holds with `soc` low until release. No slot is lost or repeated.
- R13: With bits 13:12 = 01, `suspend` lets the whole sequence finish (including `eos`), then holds before the wrap to slot 0 until release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Control word read value |
| start | input | 1 | Start-of-sequence trigger |
| seq_clr | input | 1 | Return a stopped sequencer to slot 0 |
| max_slot | input | SLOT_W | Index of the last slot in a sequence |
| suspend | input | 1 | Debug-suspend request |
| soc | output | 1 | Start-of-conversion / sampling window |
| slot | output | SLOT_W | Current slot index |
| latch | output | 1 | Result-latch strobe |
| latch_slot | output | SLOT_W | Slot whose result is being latched |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with `CONV_LAT` = 3 and the default 4-bit slot index. The short converter latency puts many full sequences, and every suspend window, within a few thousand cycles. It also leaves room to place a suspend between the latch of one slot and the end of the next conversion. Random acquisition counts of 0 to 5, both clock-halving settings and sequence lengths of 1 to 6 slots exercise both boundaries of the window counter and the single-slot sequence. Start-stop runs cover both R8 cases: the ignored restart and the one that follows `seq_clr`.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CONV_LAT = 4,
  parameter int SLOT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              start,
  input  logic              seq_clr,
  input  logic [SLOT_W-1:0] max_slot,
  input  logic              suspend,
  output logic              soc,
  output logic [SLOT_W-1:0] slot,
  output logic              latch,
  output logic [SLOT_W-1:0] latch_slot,
  output logic              eos,
  output logic              busy
);
  localparam int CW = (CONV_LAT > 1) ? $clog2(CONV_LAT) : 1;
  localparam logic [CW-1:0] CONV_END = CW'(CONV_LAT - 1);

  typedef enum logic [2:0] {S_IDLE, S_SAMP, S_CONV, S_HOLD, S_STOP} st_t;

  logic [1:0]  susp_mode;
  logic [3:0]  acq_len;
  logic        half_clk, cont, spare_a, spare_b;
  logic [1:0]  blk_cnt;
  logic        div_ph, start_pend, last_q;
  logic [3:0]  acq_cnt;
  logic [CW-1:0] conv_cnt;
  st_t         state;

  wire blk      = blk_cnt != 2'd0;
  wire soft_rst = wr_en && !blk && wr_data[14];
  wire tick     = !half_clk || div_ph;
  wire freeze   = suspend && susp_mode == 2'b11;
  wire adv      = tick && !freeze && !blk;
  wire halt_any = suspend && susp_mode != 2'b00;
  wire halt_cnv = suspend && susp_mode == 2'b10;
  wire last     = slot == max_slot;
  wire conv_done = state == S_CONV && adv && conv_cnt == CONV_END;

  assign rd_data = {2'b00, susp_mode, acq_len, half_clk, cont, spare_a, spare_b, 4'h0};
  assign soc  = state == S_SAMP;
  assign busy = state == S_SAMP || state == S_CONV || state == S_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {susp_mode, acq_len, half_clk, cont, spare_a, spare_b} <= '0;
      blk_cnt <= 2'd0;
    end else if (soft_rst) begin
      {susp_mode, acq_len, half_clk, cont, spare_a, spare_b} <= '0;
      blk_cnt <= 2'd2;
    end else if (blk) begin
      blk_cnt <= blk_cnt - 2'd1;
    end else if (wr_en) begin
      susp_mode <= wr_data[13:12];
      acq_len   <= wr_data[11:8];
      half_clk  <= wr_data[7];
      cont      <= wr_data[6];
      spare_a   <= wr_data[5];
      spare_b   <= wr_data[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      slot <= '0; latch_slot <= '0;
      latch <= 1'b0; eos <= 1'b0; last_q <= 1'b0;
      div_ph <= 1'b0; start_pend <= 1'b0;
      acq_cnt <= '0; conv_cnt <= '0;
    end else if (soft_rst) begin
      state <= S_IDLE;
      slot <= '0; latch_slot <= '0;
      latch <= 1'b0; eos <= 1'b0; last_q <= 1'b0;
      div_ph <= 1'b0; start_pend <= 1'b0;
      acq_cnt <= '0; conv_cnt <= '0;
    end else begin
      latch  <= 1'b0;
      eos    <= latch && last_q;
      div_ph <= half_clk ? !div_ph : 1'b0;
      case (state)
        S_IDLE: begin
          if (seq_clr) begin
            slot <= '0;
            start_pend <= 1'b0;
          end else if ((start || start_pend) && !halt_any && !blk) begin
            if (adv) begin
              state <= S_SAMP;
              acq_cnt <= '0;
              start_pend <= 1'b0;
            end else begin
              start_pend <= 1'b1;
            end
          end else begin
            start_pend <= 1'b0;
          end
        end
        S_SAMP: if (adv) begin
          if (acq_cnt == acq_len) begin
            state <= S_CONV;
            conv_cnt <= '0;
          end else begin
            acq_cnt <= acq_cnt + 4'd1;
          end
        end
        S_CONV: begin
          if (conv_done) begin
            latch <= 1'b1;
            latch_slot <= slot;
            last_q <= last;
            acq_cnt <= '0;
            if (last) begin
              if (cont) begin
                slot <= '0;
                state <= halt_any ? S_HOLD : S_SAMP;
              end else begin
                state <= S_STOP;
              end
            end else begin
              slot <= slot + SLOT_W'(1);
              state <= halt_cnv ? S_HOLD : S_SAMP;
            end
          end else if (adv) begin
            conv_cnt <= conv_cnt + CW'(1);
          end
        end
        S_HOLD: if (adv && !halt_any) begin
          state <= S_SAMP;
          acq_cnt <= '0;
        end
        S_STOP: if (seq_clr) begin
          slot <= '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_seq_ctrl_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic [15:0]       rd_data,
  input logic              seq_clr,
  input logic [SLOT_W-1:0] max_slot,
  input logic              suspend,
  input logic              soc,
  input logic [SLOT_W-1:0] slot,
  input logic              latch,
  input logic              eos,
  input logic              busy,
  input logic              blk
);
  // R2
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[14] && !blk) |=> (rd_data == 16'h0 && !soc && !busy && slot == '0));
  // R3
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && blk) |=> $stable(rd_data));
  // R6
  eos_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> $past(latch));
  // R6
  latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);
  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> slot <= max_slot);
  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && rd_data[13:12] == 2'b11 && !wr_en && !seq_clr) |=>
      ($stable(soc) && $stable(slot) && !latch));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .seq_clr(seq_clr), .max_slot(max_slot), .suspend(suspend), .soc(soc),
  .slot(slot), .latch(latch), .eos(eos), .busy(busy), .blk(blk)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, seq_clr = 1'b0, suspend = 1'b0;
  logic [15:0] wr_data = '0;
  logic [SW-1:0] max_slot = '0;
  wire  [15:0] rd_data;
  wire  soc, latch, eos, busy;
  wire  [SW-1:0] slot, latch_slot;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.CONV_LAT(3), .SLOT_W(SW)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .start(start), .seq_clr(seq_clr), .max_slot(max_slot), .suspend(suspend),
    .soc(soc), .slot(slot), .latch(latch), .latch_slot(latch_slot),
    .eos(eos), .busy(busy)
  );

  int checks = 0, fails = 0;
  int exp_w = 0, cur_w = 0, nsoc = 0, nlat = 0, neos = 0;
  int lat_log [256];
  logic prev_soc = 1'b0, prev_lat = 1'b0;
  logic [SW-1:0] prev_lslot = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int soc_len(input int acq, input bit half);
    return (acq + 1) * (half ? 2 : 1);
  endfunction

  function automatic logic [15:0] cword(input int mode, input int acq, input bit half, input bit cnt);
    return {2'b00, 2'(mode), 4'(acq), half, cnt, 2'b00, 4'h0};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (soc) cur_w++;
      if (!soc && prev_soc) begin
        nsoc++;
        if (exp_w != 0) chk(cur_w == exp_w, "R5 soc width", cur_w, exp_w);
        cur_w = 0;
      end
      if (latch) begin
        lat_log[nlat % 256] = int'(latch_slot);
        nlat++;
      end
      if (eos) begin
        neos++;
        chk(prev_lat && prev_lslot == max_slot, "R6 eos after last latch",
            int'(prev_lslot), int'(max_slot));
      end
      prev_soc = soc; prev_lat = latch; prev_lslot = latch_slot;
    end
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog act=hung exp=done");
    report();
  end

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start;
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic clr_seq;
    seq_clr = 1'b1; @(negedge clk); seq_clr = 1'b0;
  endtask

  task automatic wait_lat(input int n, input string tag);
    int t = 0;
    while (nlat < n && t < 5000) begin @(negedge clk); t++; end
    chk(nlat >= n, tag, nlat, n);
  endtask

  task automatic wait_eos(input int n, input string tag);
    int t = 0;
    while (neos < n && t < 5000) begin @(negedge clk); t++; end
    chk(neos >= n, tag, neos, n);
  endtask

  task automatic chk_log(input int base, input int cnt, input int mx, input string tag);
    for (int i = 0; i < cnt; i++)
      chk(lat_log[(base + i) % 256] == i % (mx + 1), tag, lat_log[(base + i) % 256], i % (mx + 1));
  endtask

  initial begin
    int b, e, s;
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
    chk(!soc && !latch && !eos && !busy && slot == 0, "R1 outputs idle",
        {soc, latch, eos, busy}, 0);

    // R4
    wr(16'hBFFF);
    chk(rd_data == 16'h3FF0, "R4 readback mask", rd_data, 16'h3FF0);
    wr(16'h0000);
    wr(16'h8A5F);
    chk(rd_data == 16'h0A50, "R4 field positions", rd_data, 16'h0A50);

    // R2 / R3
    wr(16'h7FF0);
    chk(rd_data == 16'h0, "R2 soft reset clears word", rd_data, 0);
    wr(16'h0F00);
    chk(rd_data == 16'h0, "R3 first write blocked", rd_data, 0);
    wr(16'h0F00);
    chk(rd_data == 16'h0, "R3 second write blocked", rd_data, 0);
    wr(16'h0F00);
    chk(rd_data == 16'h0F00, "R3 third write accepted", rd_data, 16'h0F00);

    // R2: soft reset in the middle of a sequence
    max_slot = 4'd3; wr(cword(0, 2, 0, 1)); exp_w = 3;
    clr_seq(); pulse_start();
    repeat (6) @(negedge clk);
    exp_w = 0;
    wr(16'h4000);
    chk(!busy && !soc && slot == 0 && rd_data == 0, "R2 sequencer reset", {busy, soc}, 0);
    repeat (4) @(negedge clk);
    cur_w = 0;

    // R5 / R6 / R8 directed start-stop
    max_slot = 4'd3; wr(cword(0, 2, 0, 0)); exp_w = soc_len(2, 0);
    clr_seq();
    b = nlat; e = neos; s = nsoc;
    pulse_start();
    wait_eos(e + 1, "R6 eos reached");
    chk_log(b, 4, 3, "R6 slot order");
    repeat (20) @(negedge clk);
    chk(nsoc == s + 4 && !busy, "R8 stays stopped", nsoc - s, 4);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(nsoc == s + 4, "R8 start ignored before clear", nsoc - s, 4);
    clr_seq();
    chk(slot == 0, "R8 clear returns to slot 0", slot, 0);
    pulse_start();
    wait_eos(e + 2, "R8 restart after clear");
    chk_log(b + 4, 4, 3, "R8 slot order after clear");

    // R5 halved converter clock
    wr(cword(0, 3, 1, 0)); exp_w = soc_len(3, 1);
    clr_seq(); b = nlat; e = neos;
    pulse_start();
    wait_eos(e + 1, "R5 halved clock sequence");
    chk_log(b, 4, 3, "R6 halved clock order");

    // R5 / R6 random configurations
    for (int it = 0; it < 8; it++) begin
      int acq, mx; bit hf;
      acq = $urandom_range(0, 5); hf = 1'($urandom_range(0, 1)); mx = $urandom_range(0, 5);
      if (it == 0) begin acq = 0; mx = 0; end
      max_slot = SW'(mx); exp_w = soc_len(acq, hf);
      wr(cword(0, acq, hf, 0));
      clr_seq(); b = nlat; e = neos;
      pulse_start();
      wait_eos(e + 1, "R6 random sequence eos");
      chk_log(b, mx + 1, mx, "R6 random slot order");
      chk(nlat - b == mx + 1, "R6 random latch count", nlat - b, mx + 1);
    end

    // R7 start while busy
    max_slot = 4'd3; wr(cword(0, 1, 0, 0)); exp_w = soc_len(1, 0);
    clr_seq(); b = nlat; e = neos; s = nsoc;
    pulse_start();
    repeat (3) @(negedge clk); pulse_start();
    repeat (5) @(negedge clk); pulse_start();
    wait_eos(e + 1, "R7 sequence completes");
    repeat (20) @(negedge clk);
    chk(nsoc - s == 4 && nlat - b == 4, "R7 busy starts ignored", nsoc - s, 4);

    // R9 continuous decided at end of sequence
    max_slot = 4'd2; wr(cword(0, 1, 0, 0));
    clr_seq(); b = nlat; e = neos;
    pulse_start();
    wait_lat(b + 1, "R9 first latch");
    wr(cword(0, 1, 0, 1));
    wait_lat(b + 4, "R9 wrapped into second sequence");
    wr(cword(0, 1, 0, 0));
    wait_eos(e + 2, "R9 second eos");
    repeat (20) @(negedge clk);
    chk(nlat - b == 6 && neos - e == 2 && !busy, "R9 wrap then stop", nlat - b, 6);
    chk_log(b, 6, 2, "R9 wrap order");

    // R10 suspend ignored
    max_slot = 4'd2; wr(cword(0, 2, 0, 0)); exp_w = soc_len(2, 0);
    clr_seq(); b = nlat; e = neos;
    suspend = 1'b1;
    pulse_start();
    wait_eos(e + 1, "R10 sequence under suspend");
    chk_log(b, 3, 2, "R10 order under suspend");
    suspend = 1'b0;

    // R11 immediate freeze
    max_slot = 4'd2; wr(cword(3, 3, 0, 0)); exp_w = soc_len(3, 0) + 5;
    clr_seq(); b = nlat; e = neos;
    pulse_start();
    @(negedge clk);
    suspend = 1'b1;
    repeat (5) @(negedge clk);
    chk(soc && nlat == b, "R11 frozen in sampling", {soc, 1'b0}, 2);
    suspend = 1'b0;
    while (soc) @(negedge clk);
    @(negedge clk);
    exp_w = soc_len(3, 0);
    wait_eos(e + 1, "R11 resume completes");
    chk_log(b, 3, 2, "R11 no lost or repeated slot");

    // R12 halt after current conversion
    max_slot = 4'd3; wr(cword(2, 1, 0, 0)); exp_w = soc_len(1, 0);
    clr_seq(); b = nlat; e = neos;
    pulse_start();
    while (!latch) @(negedge clk);
    suspend = 1'b1;
    wait_lat(b + 2, "R12 current conversion latched");
    s = nsoc;
    repeat (15) @(negedge clk);
    chk(nlat == b + 2 && nsoc == s && !soc && busy, "R12 held after conversion", nlat - b, 2);
    suspend = 1'b0;
    wait_eos(e + 1, "R12 resume completes");
    chk_log(b, 4, 3, "R12 no lost or repeated slot");

    // R13 halt after sequence in continuous mode
    max_slot = 4'd2; wr(cword(1, 1, 0, 1));
    clr_seq(); b = nlat; e = neos;
    pulse_start();
    while (!latch) @(negedge clk);
    suspend = 1'b1;
    wait_eos(e + 1, "R13 sequence finishes under suspend");
    s = nsoc;
    repeat (15) @(negedge clk);
    chk(nsoc == s && nlat == b + 3 && busy, "R13 held before wrap", nlat - b, 3);
    suspend = 1'b0;
    wait_lat(b + 4, "R13 resumes at slot 0");
    wr(cword(1, 1, 0, 0));
    wait_eos(e + 2, "R13 final eos");
    chk_log(b, 6, 2, "R13 order across halt");

    report();
  end
endmodule